// File: doc/BRIEF.md
# Serial Real-Time Clock and Retained-Memory Target

This block is the device side of a select-framed serial link that works like SPI mode 0. It keeps a 32-bit seconds count, advanced by a once-per-second pulse, and a 64-byte retained memory. A host opens a frame by pulling the active-low select low. It clocks in a 32-bit command word and then moves data in the same frame. A frame can load a new time, read the current time, or stream out the memory from its first byte. Releasing select ends the frame at any point.

The serial pins are sampled by the block's own system clock through two-stage synchronizers. Edges of the serial clock are found in the system-clock domain, so the serial clock must run several times slower than the system clock. Loading the memory is not part of this block. The retained contents are held as a fixed computed pattern.

Top module: `rtc_sram_target`

## Requirements
- R1: After reset the seconds count is 0 and `miso` is low. `miso` is also low whenever select has been high for three system clocks.
- R2: Each of `cs_n`, `sck` and `mosi` passes two synchronizer flops. A serial edge acts on the third system-clock edge after the pin changes. Input bits are taken on rising `sck`, output bits change on falling `sck`, and both go most significant bit first. The first 32 bits of every frame form the command word.
- R3: Command 0xA0000000 loads the next 32 received bits as the seconds count. Any bits after those 32 in the same frame are ignored.
- R4: Command 0x20000000 returns the seconds count, MSB first, on the 32 bits after the command. Every later bit in the frame is 0.
- R5: Each system-clock cycle with `sec_tick` high adds one to the seconds count, with wrap-around.
- R6: A time read returns the count as it stood when the command was decoded. A tick during the read-out does not change the returned value, but it does change the count.
- R7: Command 0x20000100 streams the memory from address 0, one byte after another, each byte MSB first. Byte `a` holds (0x5A + 37·a) mod 256.
- R8: A memory stream that runs past byte 63 continues at byte 0.
- R9: Any other command word leaves `miso` at 0 for the rest of the frame and does not change the seconds count.
- R10: Raising select mid-frame drops a partly received time write without changing the count. The next frame starts again with a command word.
- R11: If `sec_tick` is high in the same cycle that a time write completes, the written value is stored with no increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| sec_tick | input | 1 | One-cycle pulse per second |
| miso | output | 1 | Serial data to the host |

## Verification
A wrong bit counter shifts the command boundary. The fault shows in the first read frame, as a time value rotated by one or more bits or as data where zeros belong. A wrong mode or decode turns a valid command into silence on `miso`, or makes an unknown command produce data. The fault is visible within the 32 bits after the command.

A bad seconds count or a missed write priority only shows on the next time read. For that reason every write and tick scenario is closed by a read frame. The memory address walk is followed through a full lap and past the wrap, so an address error appears at the byte where it happens.

// File: rtl/rtc_sram_target.sv
module rtc_sram_target #(
  parameter int          WORD_W      = 32,
  parameter int          SRAM_BYTES  = 64,
  parameter logic [31:0] CMD_RD_TIME = 32'h2000_0000,
  parameter logic [31:0] CMD_WR_TIME = 32'hA000_0000,
  parameter logic [31:0] CMD_RD_MEM  = 32'h2000_0100,
  parameter logic [7:0]  MEM_SEED    = 8'h5A,
  parameter logic [7:0]  MEM_STEP    = 8'd37
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic sec_tick,
  output logic miso
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int ADDR_W = $clog2(SRAM_BYTES);
  localparam logic [2:0] M_CMD = 3'd0, M_RXT = 3'd1, M_TXT = 3'd2, M_TXM = 3'd3, M_IGN = 3'd4;

  logic [1:0]        cs_q, mosi_q;
  logic [2:0]        sck_q;
  logic [WORD_W-1:0] rx, tx, time_q;
  logic [CNT_W-1:0]  bitcnt;
  logic [2:0]        mode, bytebit;
  logic [ADDR_W-1:0] addr;
  logic              miso_q;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return MEM_SEED + 8'(a) * MEM_STEP;
  endfunction

  wire desel = cs_q[1];
  wire rise  = !desel && sck_q[1] && !sck_q[2];
  wire fall  = !desel && !sck_q[1] && sck_q[2];
  wire [WORD_W-1:0] word = {rx[WORD_W-2:0], mosi_q[1]};
  wire last    = rise && (bitcnt == CNT_W'(WORD_W-1));
  wire wr_fire = last && (mode == M_RXT);

  assign miso = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 2'b11;
      sck_q   <= '0;
      mosi_q  <= '0;
      rx      <= '0;
      tx      <= '0;
      time_q  <= '0;
      bitcnt  <= '0;
      mode    <= M_CMD;
      bytebit <= '0;
      addr    <= '0;
      miso_q  <= 1'b0;
    end else begin
      cs_q   <= {cs_q[0], cs_n};
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};

      if (wr_fire)       time_q <= word;
      else if (sec_tick) time_q <= time_q + 1'b1;

      if (desel) begin
        bitcnt  <= '0;
        mode    <= M_CMD;
        tx      <= '0;
        addr    <= '0;
        bytebit <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (rise) begin
          rx     <= word;
          bitcnt <= bitcnt + 1'b1;
          if (last) begin
            case (mode)
              M_CMD: begin
                if (word == CMD_RD_TIME) begin
                  mode <= M_TXT;
                  tx   <= time_q;
                end else if (word == CMD_WR_TIME) begin
                  mode <= M_RXT;
                end else if (word == CMD_RD_MEM) begin
                  mode    <= M_TXM;
                  tx      <= {mem_byte('0), (WORD_W-8)'(0)};
                  addr    <= ADDR_W'(1);
                  bytebit <= '0;
                end else begin
                  mode <= M_IGN;
                end
              end
              M_RXT:   mode <= M_IGN;
              default: ;
            endcase
          end
        end
        if (fall) begin
          case (mode)
            M_TXT: begin
              miso_q <= tx[WORD_W-1];
              tx     <= tx << 1;
            end
            M_TXM: begin
              miso_q  <= tx[WORD_W-1];
              bytebit <= bytebit + 1'b1;
              if (bytebit == 3'd7) begin
                tx   <= {mem_byte(addr), (WORD_W-8)'(0)};
                addr <= addr + 1'b1;
              end else begin
                tx <= tx << 1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rtc_sram_target_chk.sv
module rtc_sram_target_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desel,
  input logic              miso,
  input logic              sec_tick,
  input logic              wr_fire,
  input logic              quiet_mode,
  input logic              cmd_mode,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] time_q,
  input logic [CNT_W-1:0]  bitcnt
);
  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !miso);

  // R9
  silent_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_mode |-> !miso);

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> time_q == $past(wr_data));

  // R5
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_fire) |=> time_q == $past(time_q) + 1'b1);

  // R5
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_fire) |=> $stable(time_q));

  // R10
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> (bitcnt == '0) && cmd_mode);
endmodule

bind rtc_sram_target rtc_sram_target_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desel      (desel),
  .miso       (miso),
  .sec_tick   (sec_tick),
  .wr_fire    (wr_fire),
  .quiet_mode (mode == M_CMD || mode == M_IGN),
  .cmd_mode   (mode == M_CMD),
  .wr_data    (word),
  .time_q     (time_q),
  .bitcnt     (bitcnt)
);

// File: tb/tb_rtc_sram_target.sv
module tb_rtc_sram_target;
  localparam int H = 6;
  localparam logic [31:0] RD = 32'h2000_0000, WR = 32'hA000_0000, MEM = 32'h2000_0100;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, sec_tick = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  logic dbits [0:1023];

  always #4 clk = ~clk;

  rtc_sram_target dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
                       .sec_tick(sec_tick), .miso(miso));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic b, input logic tick, output logic o);
    mosi = b;
    repeat (H) @(negedge clk);
    o = miso;
    sck = 1'b1;
    if (tick) begin
      @(negedge clk); @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      repeat (H-3) @(negedge clk);
    end else begin
      repeat (H) @(negedge clk);
    end
    sck = 1'b0;
  endtask

  task automatic frame(input logic [31:0] cmd, input int nbits, input logic [31:0] wdata,
                       input int tick_at, output logic cmd_quiet);
    logic o;
    cmd_quiet = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      xfer_bit(cmd[31-i], 1'b0, o);
      if (o !== 1'b0) cmd_quiet = 1'b0;
    end
    for (int i = 0; i < nbits; i++) begin
      xfer_bit(i < 32 ? wdata[31-i] : 1'b1, tick_at == i, o);
      dbits[i] = o;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [31:0] word_at(input int base);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = dbits[base+i];
    return w;
  endfunction

  task automatic read_time(output logic [31:0] v);
    logic q;
    frame(RD, 32, '0, -1, q);
    v = word_at(0);
  endtask

  task automatic tick_pulse();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic q;
    chk(miso === 1'b0, "R1 miso after reset", {31'b0, miso}, 32'h0);
    frame(RD, 32, '0, -1, q);
    v = word_at(0);
    chk(v === 32'h0, "R1 time after reset", v, 32'h0);
    chk(q, "R2 miso quiet during command", {31'b0, q}, 32'h1);
    chk(miso === 1'b0, "R1 miso after deselect", {31'b0, miso}, 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    logic q, tail;
    frame(WR, 40, 32'h1234_5678, -1, q);
    frame(RD, 40, '0, -1, q);
    v = word_at(0);
    chk(v === 32'h1234_5678, "R3 written time read back", v, 32'h1234_5678);
    tail = 1'b0;
    for (int i = 32; i < 40; i++) tail = tail | dbits[i];
    chk(tail === 1'b0, "R4 zeros after time word", {31'b0, tail}, 32'h0);
    frame(WR, 32, 32'h8000_0001, -1, q);
    read_time(v);
    chk(v === 32'h8000_0001, "R2 MSB-first pattern", v, 32'h8000_0001);
  endtask

  task automatic t_ticks();
    logic [31:0] v;
    logic q;
    frame(WR, 32, 32'hFFFF_FFFE, -1, q);
    repeat (3) tick_pulse();
    read_time(v);
    chk(v === 32'h0000_0001, "R5 three ticks with wrap", v, 32'h1);
  endtask

  task automatic t_tick_during_read();
    logic [31:0] v;
    logic q;
    frame(WR, 32, 32'h0000_0100, -1, q);
    frame(RD, 32, '0, 5, q);
    v = word_at(0);
    chk(v === 32'h0000_0100, "R6 snapshot unaffected by tick", v, 32'h100);
    read_time(v);
    chk(v === 32'h0000_0101, "R6 tick still counted", v, 32'h101);
  endtask

  task automatic t_tick_on_write();
    logic [31:0] v;
    logic q;
    frame(WR, 32, 32'h0BAD_CAFE, 31, q);
    read_time(v);
    chk(v === 32'h0BAD_CAFE, "R11 write beats tick", v, 32'h0BADCAFE);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    logic q;
    frame(WR, 32, 32'h0000_0042, -1, q);
    frame(WR, 16, 32'hFFFF_FFFF, -1, q);
    read_time(v);
    chk(v === 32'h0000_0042, "R10 partial write dropped", v, 32'h42);
  endtask

  task automatic t_mem();
    logic q;
    logic [7:0] got, exp;
    int bad = 0;
    frame(MEM, 66*8, '0, -1, q);
    for (int b = 0; b < 66; b++) begin
      for (int i = 0; i < 8; i++) got[7-i] = dbits[b*8+i];
      exp = 8'(8'h5A + (b % 64) * 37);
      if (got !== exp) bad++;
      if (b == 0 || b == 1 || b == 63)
        chk(got === exp, "R7 memory byte", {24'b0, got}, {24'b0, exp});
      if (b >= 64)
        chk(got === exp, "R8 wrap to byte 0", {24'b0, got}, {24'b0, exp});
    end
    chk(bad == 0, "R7 full memory lap", bad, 0);
  endtask

  task automatic t_bad_cmd();
    logic [31:0] v;
    logic q, any;
    frame(WR, 32, 32'h0000_7777, -1, q);
    frame(32'h2000_0001, 48, 32'hFFFF_FFFF, -1, q);
    any = 1'b0;
    for (int i = 0; i < 48; i++) any = any | dbits[i];
    chk(any === 1'b0, "R9 unknown command silent", {31'b0, any}, 32'h0);
    frame(32'hA000_0001, 32, 32'h0000_1111, -1, q);
    read_time(v);
    chk(v === 32'h0000_7777, "R9 time unchanged", v, 32'h7777);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_ticks();
    t_tick_during_read();
    t_tick_on_write();
    t_abort();
    t_mem();
    t_bad_cmd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule